// File: doc/BRIEF.md
# Slot-Mapped Network Interrupt Aggregator

This block gathers per-port network interrupt requests from seven adapter bays into two 32-bit status words and drives one level-sensitive interrupt line toward the processor. Each bay owns an 8-bit field of port bits. A fixed table places these fields across the two words, and the placement is not in slot order. Adapter-side logic raises and lowers individual bits with single-cycle set and clear pulses. Each pulse is indexed by slot and port on a flat 56-bit vector.

The processor reaches the block through a plain register port made of valid, write, address and write-data, with combinational read data. It can read both status words. It can read and write one mask word per status word. The interrupt line is registered. It is high whenever any status bit is set while the matching mask bit is also set.

Top module: `netirq_aggregator`

## Requirements
- R1: After a synchronous active-low reset, both status words and both mask words are zero and `irq_o` is low.
- R2: A set pulse on input bit `slot*8+port` of `evt_set` sets status bit (base+port). Slot 0 uses word A base 0, slot 1 word A base 8, slot 4 word A base 16, slot 3 word A base 24, slot 2 word B base 8, slot 6 word B base 16 and slot 5 word B base 24.
- R3: A clear pulse on input bit `slot*8+port` of `evt_clr` clears the status bit that R2 maps for that slot and port. Other bits keep their values.
- R4: When set and clear pulses hit the same bit in one cycle, the bit ends up set. Pulses on different bits in the same cycle all take effect.
- R5: A read at any address 0x10 to 0x13 returns status word A. A read at any address 0x18 to 0x1B returns status word B.
- R6: Mask word A is read and written at exactly address 0x20, and mask word B at exactly 0x28. A write to any other address leaves both masks unchanged.
- R7: Writes to the status addresses 0x10 to 0x1B change neither status word.
- R8: `irq_o` is high exactly when (status A AND mask A) or (status B AND mask B) is nonzero. It takes its new value at the same clock edge that updates the status or mask register.
- R9: A read at any address other than the status and mask addresses returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_set | input | 56 | Per slot/port set pulses, bit index slot*8+port |
| evt_clr | input | 56 | Per slot/port clear pulses, bit index slot*8+port |
| csr_valid | input | 1 | Register access strobe |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 8 | Byte address of the access |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational, zero when no read is strobed |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Some behaviours are checked on every cycle. These are: every set pulse lands in exactly one status bit; a set bit survives a same-cycle clear; a clear-only bit drops; status holds with no pulses; masks move only on a write to their own address; and the interrupt always equals the masked OR of the registers. Other behaviours only the bench scenarios can show. These are the exact placement of each bay field in the status words, the address aliasing of the status reads, zero data on unmapped reads, and the exact edge at which the interrupt rises and falls.

// File: rtl/netirq_pkg.sv
// Package: shared sizes, register addresses and the fixed slot-to-field table.
// Assumes seven slots of eight ports and two 32-bit status words.
package netirq_pkg;
    localparam int NUM_SLOTS = 7;
    localparam int PORTS     = 8;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 2;
    localparam int ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] ADR_STAT_A = 8'h10;
    localparam logic [ADDR_W-1:0] ADR_STAT_B = 8'h18;
    localparam logic [ADDR_W-1:0] ADR_MASK_A = 8'h20;
    localparam logic [ADDR_W-1:0] ADR_MASK_B = 8'h28;

    // Which status word (0 = A, 1 = B) holds a slot's field.
    function automatic int slot_word(int s);
        case (s)
            2, 5, 6: return 1;
            default: return 0;
        endcase
    endfunction

    // Lowest bit of a slot's field inside its status word.
    function automatic int slot_base(int s);
        case (s)
            1, 2:    return 8;
            4, 6:    return 16;
            3, 5:    return 24;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/netirq_slot_map.sv
// Module: scatters flat slot/port pulses into per-word set and clear vectors
// using the package table. Assumes slot fields never overlap.
module netirq_slot_map
    import netirq_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int NPORT = PORTS,
    parameter int DW    = WORD_W,
    parameter int NW    = NUM_WORDS,
    localparam int EW   = NSLOT * NPORT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EW-1:0]         evt_set,
    input  logic [EW-1:0]         evt_clr,
    output logic [NW-1:0][DW-1:0] set_w,
    output logic [NW-1:0][DW-1:0] clr_w
);
    // Place each slot's port pulses into its mapped field.
    always_comb begin
        set_w = '0;
        clr_w = '0;
        for (int s = 0; s < NSLOT; s++) begin
            set_w[slot_word(s)][slot_base(s) +: NPORT] = evt_set[s*NPORT +: NPORT];
            clr_w[slot_word(s)][slot_base(s) +: NPORT] = evt_clr[s*NPORT +: NPORT];
        end
    end

    // R2: no set pulse is lost or duplicated by the scatter.
    p_map_lossless_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(set_w) == $countones(evt_set));
endmodule

// File: rtl/netirq_status_bank.sv
// Module: holds the status words. A set pulse beats a same-cycle clear.
// Also exposes the next-state value so the interrupt can be registered in step.
module netirq_status_bank
    import netirq_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int NW = NUM_WORDS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NW-1:0][DW-1:0] set_w,
    input  logic [NW-1:0][DW-1:0] clr_w,
    output logic [NW-1:0][DW-1:0] st_q,
    output logic [NW-1:0][DW-1:0] st_d
);
    for (genvar w = 0; w < NW; w++) begin : g_word
        // Next status: clear first, then set, so set wins.
        always_comb st_d[w] = (st_q[w] & ~clr_w[w]) | set_w[w];

        // Status word register with synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) st_q[w] <= '0;
            else        st_q[w] <= st_d[w];
        end

        // R4: every bit set last cycle is high now, even if also cleared.
        p_set_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (set_w[w] != '0) |=> ((st_q[w] & $past(set_w[w])) == $past(set_w[w])));
        // R3: a clear without a matching set drops the bit.
        p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
            ((clr_w[w] & ~set_w[w]) != '0) |=> ((st_q[w] & $past(clr_w[w] & ~set_w[w])) == '0));
        // R7: without pulses the word holds, whatever the CPU does.
        p_status_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (set_w[w] == '0 && clr_w[w] == '0) |=> $stable(st_q[w]));
    end
endmodule

// File: rtl/netirq_csr.sv
// Module: mask registers and the read multiplexer. Assumes single-cycle
// accesses with combinational read data; status addresses alias on the low two bits.
module netirq_csr
    import netirq_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int NW = NUM_WORDS,
    parameter int AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csr_valid,
    input  logic                  csr_write,
    input  logic [AW-1:0]         csr_addr,
    input  logic [DW-1:0]         csr_wdata,
    input  logic [NW-1:0][DW-1:0] st_q,
    output logic [DW-1:0]         csr_rdata,
    output logic [NW-1:0][DW-1:0] mask_q,
    output logic [NW-1:0][DW-1:0] mask_d
);
    logic hit_sa, hit_sb, hit_ma, hit_mb, wr_ma, wr_mb;

    // Address decode: status words by 4-byte window, masks by exact match.
    always_comb begin
        hit_sa = csr_addr[AW-1:2] == ADR_STAT_A[AW-1:2];
        hit_sb = csr_addr[AW-1:2] == ADR_STAT_B[AW-1:2];
        hit_ma = csr_addr == ADR_MASK_A;
        hit_mb = csr_addr == ADR_MASK_B;
        wr_ma  = csr_valid && csr_write && hit_ma;
        wr_mb  = csr_valid && csr_write && hit_mb;
    end

    // Next mask values, loaded only by a write to their own address.
    always_comb begin
        mask_d[0] = wr_ma ? csr_wdata : mask_q[0];
        mask_d[1] = wr_mb ? csr_wdata : mask_q[1];
    end

    // Mask registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // Read multiplexer; unmapped addresses and non-reads give zero.
    always_comb begin
        csr_rdata = '0;
        if (csr_valid && !csr_write) begin
            if (hit_sa)      csr_rdata = st_q[0];
            else if (hit_sb) csr_rdata = st_q[1];
            else if (hit_ma) csr_rdata = mask_q[0];
            else if (hit_mb) csr_rdata = mask_q[1];
        end
    end

    // R6: a mask moves only on a write to its own address.
    p_mask_a_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_valid && csr_write && csr_addr == ADR_MASK_A) |=> $stable(mask_q[0]));
    p_mask_b_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_valid && csr_write && csr_addr == ADR_MASK_B) |=> $stable(mask_q[1]));
    // R6: a mask write stores the written data.
    p_mask_a_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_write && csr_addr == ADR_MASK_A) |=> mask_q[0] == $past(csr_wdata));
endmodule

// File: rtl/netirq_aggregator.sv
// Module: top of the network interrupt aggregator. Combines the slot map,
// the status bank and the register port, and registers a single level interrupt.
// Assumes the clock and the synchronous active-low reset are shared by all parts.
module netirq_aggregator
    import netirq_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int NPORT = PORTS,
    parameter int DW    = WORD_W,
    parameter int AW    = ADDR_W,
    localparam int NW   = NUM_WORDS,
    localparam int EW   = NSLOT * NPORT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [EW-1:0] evt_set,
    input  logic [EW-1:0] evt_clr,
    input  logic          csr_valid,
    input  logic          csr_write,
    input  logic [AW-1:0] csr_addr,
    input  logic [DW-1:0] csr_wdata,
    output logic [DW-1:0] csr_rdata,
    output logic          irq_o
);
    logic [NW-1:0][DW-1:0] set_w, clr_w, st_q, st_d, mask_q, mask_d;
    logic                  irq_d;

    netirq_slot_map #(.NSLOT(NSLOT), .NPORT(NPORT), .DW(DW), .NW(NW)) i_map (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
        .set_w(set_w), .clr_w(clr_w));

    netirq_status_bank #(.DW(DW), .NW(NW)) i_bank (
        .clk(clk), .rst_n(rst_n), .set_w(set_w), .clr_w(clr_w),
        .st_q(st_q), .st_d(st_d));

    netirq_csr #(.DW(DW), .NW(NW), .AW(AW)) i_csr (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_write(csr_write),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .st_q(st_q),
        .csr_rdata(csr_rdata), .mask_q(mask_q), .mask_d(mask_d));

    // Interrupt request from the next-state status and mask values.
    always_comb begin
        irq_d = 1'b0;
        for (int w = 0; w < NW; w++) irq_d = irq_d | (|(st_d[w] & mask_d[w]));
    end

    // Interrupt register, updated on the same edge as status and masks.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= irq_d;
    end

    // R8: the output always matches the masked OR of the held registers.
    p_irq_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((|(st_q[0] & mask_q[0])) || (|(st_q[1] & mask_q[1]))));
    // R1: right after reset is released, the interrupt is low.
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/test_netirq_aggregator.sv
module test_netirq_aggregator;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    // Vector: kind(2) slot(3) port(3) data(32) expA(32) expB(32) irq(1)
    // kind 0 = set pulse, 1 = clear pulse, 2 = write mask A, 3 = write mask B
    localparam logic [104:0] VEC [NV] = '{
        {2'd0, 3'd0, 3'd0, 32'h0,        32'h00000001, 32'h00000000, 1'b0},
        {2'd0, 3'd1, 3'd7, 32'h0,        32'h00008001, 32'h00000000, 1'b0},
        {2'd0, 3'd2, 3'd3, 32'h0,        32'h00008001, 32'h00000800, 1'b0},
        {2'd0, 3'd3, 3'd1, 32'h0,        32'h02008001, 32'h00000800, 1'b0},
        {2'd0, 3'd4, 3'd2, 32'h0,        32'h02048001, 32'h00000800, 1'b0},
        {2'd0, 3'd5, 3'd0, 32'h0,        32'h02048001, 32'h01000800, 1'b0},
        {2'd0, 3'd6, 3'd6, 32'h0,        32'h02048001, 32'h01400800, 1'b0},
        {2'd2, 3'd0, 3'd0, 32'h00040000, 32'h02048001, 32'h01400800, 1'b1},
        {2'd1, 3'd4, 3'd2, 32'h0,        32'h02008001, 32'h01400800, 1'b0},
        {2'd3, 3'd0, 3'd0, 32'h00000800, 32'h02008001, 32'h01400800, 1'b1},
        {2'd1, 3'd2, 3'd3, 32'h0,        32'h02008001, 32'h01400000, 1'b0},
        {2'd2, 3'd0, 3'd0, 32'hFFFFFFFF, 32'h02008001, 32'h01400000, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [55:0] evt_set = '0;
    logic [55:0] evt_clr = '0;
    logic        csr_valid = 1'b0;
    logic        csr_write = 1'b0;
    logic [7:0]  csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        irq_o;
    int          checks = 0;
    int          failures = 0;
    logic [31:0] rd;

    netirq_aggregator i_netirq_aggregator (
        .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .evt_clr(evt_clr),
        .csr_valid(csr_valid), .csr_write(csr_write), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_o(irq_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic csr_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = 1'b0; csr_addr = a;
        #1 d = csr_rdata;
        csr_valid = 1'b0;
    endtask

    task automatic csr_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = a; csr_wdata = d;
        @(posedge clk); #1;
        csr_valid = 1'b0; csr_write = 1'b0;
    endtask

    task automatic pulse(logic [55:0] s, logic [55:0] c);
        @(negedge clk);
        evt_set = s; evt_clr = c;
        @(posedge clk); #1;
        evt_set = '0; evt_clr = '0;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        apply_reset();
        // R1: reset state
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        csr_rd(8'h10, rd); check("R1 statusA", rd, 32'h0);
        csr_rd(8'h18, rd); check("R1 statusB", rd, 32'h0);
        csr_rd(8'h20, rd); check("R1 maskA", rd, 32'h0);

        // R2 R3 R8: table walk, cumulative state
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  k;
            logic [2:0]  sl, pt;
            logic [31:0] dat, ea, eb;
            logic        ei;
            {k, sl, pt, dat, ea, eb, ei} = VEC[i];
            case (k)
                2'd0: pulse(56'd1 << (sl*8 + pt), '0);
                2'd1: pulse('0, 56'd1 << (sl*8 + pt));
                2'd2: csr_wr(8'h20, dat);
                default: csr_wr(8'h28, dat);
            endcase
            check("R8 irq vector", {31'b0, irq_o}, {31'b0, ei});
            csr_rd(8'h10, rd); check("R2/R3 statusA vector", rd, ea);
            csr_rd(8'h18, rd); check("R2/R3 statusB vector", rd, eb);
        end

        // R7: status writes ignored
        csr_wr(8'h10, 32'h0);
        csr_wr(8'h19, 32'hFFFFFFFF);
        csr_rd(8'h10, rd); check("R7 statusA", rd, 32'h02008001);
        csr_rd(8'h18, rd); check("R7 statusB", rd, 32'h01400000);
        check("R7 irq", {31'b0, irq_o}, 32'h1);

        // R5: aliased status addresses
        csr_rd(8'h13, rd); check("R5 0x13", rd, 32'h02008001);
        csr_rd(8'h11, rd); check("R5 0x11", rd, 32'h02008001);
        csr_rd(8'h1A, rd); check("R5 0x1A", rd, 32'h01400000);
        csr_rd(8'h1B, rd); check("R5 0x1B", rd, 32'h01400000);

        // R9: unmapped reads
        csr_rd(8'h14, rd); check("R9 0x14", rd, 32'h0);
        csr_rd(8'h24, rd); check("R9 0x24", rd, 32'h0);
        csr_rd(8'h2C, rd); check("R9 0x2C", rd, 32'h0);
        csr_rd(8'h00, rd); check("R9 0x00", rd, 32'h0);

        // R6: mask readback and near-miss write
        csr_wr(8'h21, 32'h0);
        csr_rd(8'h20, rd); check("R6 maskA", rd, 32'hFFFFFFFF);
        csr_rd(8'h28, rd); check("R6 maskB", rd, 32'h00000800);

        // R4: same-bit set and clear -> set; different bits both apply
        pulse(56'd1 << 5, 56'd1 << 5);
        csr_rd(8'h10, rd); check("R4 same bit", rd, 32'h02008021);
        pulse(56'd1 << (6*8 + 0), 56'd1 << (5*8 + 0));
        csr_rd(8'h18, rd); check("R4 mixed bits", rd, 32'h00410000);

        // R8: edge timing of a mask write
        csr_wr(8'h20, 32'h0);
        csr_wr(8'h28, 32'h0);
        check("R8 masked off", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = 1'b1; csr_addr = 8'h28; csr_wdata = 32'h00010000;
        #1 check("R8 before edge", {31'b0, irq_o}, 32'h0);
        @(posedge clk); #1;
        csr_valid = 1'b0; csr_write = 1'b0;
        check("R8 after edge", {31'b0, irq_o}, 32'h1);

        // R3: clear drops the only unmasked bit
        pulse('0, 56'd1 << (6*8 + 0));
        csr_rd(8'h18, rd); check("R3 statusB", rd, 32'h00400000);
        check("R3 irq", {31'b0, irq_o}, 32'h0);

        // R1: reset mid-run
        csr_wr(8'h20, 32'hFFFFFFFF);
        check("R1 pre-reset irq", {31'b0, irq_o}, 32'h1);
        apply_reset();
        check("R1 irq again", {31'b0, irq_o}, 32'h0);
        csr_rd(8'h10, rd); check("R1 statusA again", rd, 32'h0);
        csr_rd(8'h18, rd); check("R1 statusB again", rd, 32'h0);
        csr_rd(8'h20, rd); check("R1 maskA again", rd, 32'h0);
        csr_rd(8'h28, rd); check("R1 maskB again", rd, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule